// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates interrupts for a small 8-bit CPU core. It collects triggers from three kinds of source. Five external pins are each watched for a rising or a falling edge. Fourteen internal peripheral events arrive as single-cycle pulses: a counter overflow, serial transfer completions, six timer underflows, a conversion done and two display events. The last source is a software-break strobe. Every maskable vector slot has a request bit, which only hardware can set, and an enable bit, which software loads.

At each instruction boundary, the controller combines the pending requests with their enables and with the CPU's global interrupt-disable flag. It then selects the highest-priority candidate and presents the even address of that candidate's vector pair. In the same cycle it tells the core to set its disable flag, and the accepted request is cleared at that clock edge. The controller treats reset as the top-priority entry, served once at the first boundary after reset. Four slots are shared by two sources, and a select bit decides which source feeds each of them. Stacking and the vector fetch belong to the core. A pulse on the acknowledge output is the core's signal to do them.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, req_o and en_o are all zero and take_o is low while boundary_i is low. The first boundary after reset gives take_o=1 with vec_o=16'hFFFC, ahead of any pending source.
- R2: External pin p (ext_pin_i[p]) passes through two synchronizing flops. An edge of the polarity chosen by ext_rise_i[p] (1 = rising, 0 = falling) sets the request of its slot at the third rising clock edge after the pin changes. An edge of the other polarity sets nothing.
- R3: An internal event pulse sets its slot's request at the next clock edge. Slots map as follows: slot0..2 = pins 0..2, slot3 = evt0, slot4 = evt1/evt2 (share_sel_i[0]), slot5 = evt3/evt4 (share_sel_i[1]), slot6..11 = evt5..evt10, slot12 = pin 3, slot13 = pin 4/evt11 (share_sel_i[2]), slot14 = evt12/evt13 (share_sel_i[3]). Select 0 picks the first source and select 1 picks the second. A pulse from the unselected source sets nothing.
- R4: A request write (req_wr_i) clears each bit whose req_wdata_i bit is 0 and leaves each bit written 1 unchanged. A hardware set in the same cycle wins over the clear.
- R5: An enable write (en_wr_i) loads en_wdata_i into en_o at the next edge.
- R6: A maskable slot is taken only when its request bit is 1, its enable bit is 1 and iflag_i is 0.
- R7: Among eligible slots, the lowest slot number wins. Slot k gives vec_o = 16'hFFFA - 2k.
- R8: A brk_i strobe latches a break request. The break is served with vec_o=16'hFFDC whatever iflag_i or any enable holds, and it ranks below every maskable slot.
- R9: On acceptance, take_o and set_iflag_o are 1 and vec_o is even. Only the accepted request bit is cleared, at that edge.
- R10: take_o is never 1 while boundary_i is 0, so a pending request waits for the next boundary.
- R11: Changing ext_rise_i[p] while pin p sits at the newly active level sets the request of that pin's slot at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin_i | input | 5 | Asynchronous external interrupt pins |
| ext_rise_i | input | 5 | Per-pin edge polarity, 1 = rising |
| evt_i | input | 14 | Peripheral event pulses |
| share_sel_i | input | 4 | Source select for the four shared slots |
| req_wr_i | input | 1 | Request write strobe (clear-only) |
| req_wdata_i | input | 15 | Request write data; 0 clears |
| en_wr_i | input | 1 | Enable write strobe |
| en_wdata_i | input | 15 | Enable write data |
| brk_i | input | 1 | Software-break strobe |
| iflag_i | input | 1 | CPU global interrupt-disable flag |
| boundary_i | input | 1 | Instruction-boundary strobe |
| req_o | output | 15 | Request bits per maskable slot |
| en_o | output | 15 | Enable bits per maskable slot |
| take_o | output | 1 | Interrupt accepted this cycle |
| set_iflag_o | output | 1 | Core must set its disable flag |
| vec_o | output | 16 | Even address of the vector pair |

## Verification
The checker takes three things for granted. iflag_i, boundary_i and the write strobes are steady for the whole cycle in which they are sampled. An event pulse lasts exactly one cycle, so one pulse is one request. The core raises boundary_i only at instruction edges, although the controller itself places no spacing rule on it. The stimulus drives every input just after a rising edge and holds it until the next one. It gives events as single-cycle pulses and keeps pin changes and polarity flips at random, infrequent intervals, so the synchronizer latency and the spurious-request case can both be seen and predicted.

// File: rtl/irqc_pkg.sv
// Package: shared constants and the slot-to-source map of the interrupt controller.
// Assumes source ids are pins first (0..NUM_EXT-1), then events.
package irqc_pkg;
    localparam int NUM_EXT   = 5;
    localparam int NUM_EVT   = 14;
    localparam int NUM_SRC   = NUM_EXT + NUM_EVT;
    localparam int NUM_MSLOT = 15;
    localparam int NUM_SEL   = 4;
    localparam int NUM_CAND  = NUM_MSLOT + 1;
    localparam int SLOT_W    = $clog2(NUM_CAND);
    localparam int VEC_W     = 16;
    localparam int EVT_BASE  = NUM_EXT;

    // First (select = 0) source id of a maskable slot.
    function automatic int prim_src(input int s);
        case (s)
            0, 1, 2:  return s;
            3:        return EVT_BASE + 0;
            4:        return EVT_BASE + 1;
            5:        return EVT_BASE + 3;
            12:       return 3;
            13:       return 4;
            14:       return EVT_BASE + 12;
            default:  return EVT_BASE + 5 + (s - 6);
        endcase
    endfunction

    // Second (select = 1) source id, or -1 for an unshared slot.
    function automatic int alt_src(input int s);
        case (s)
            4:        return EVT_BASE + 2;
            5:        return EVT_BASE + 4;
            13:       return EVT_BASE + 11;
            14:       return EVT_BASE + 13;
            default:  return -1;
        endcase
    endfunction

    // Index of the select bit that steers a shared slot.
    function automatic int sel_idx(input int s);
        case (s)
            5:        return 1;
            13:       return 2;
            14:       return 3;
            default:  return 0;
        endcase
    endfunction
endpackage

// File: rtl/irqc_pin_edge.sv
// Module: synchronizes asynchronous pins and flags the selected edge per pin.
// Assumes the polarity input is quasi-static; a flip behaves like an edge of
// the compared level, which is the intended spurious-request behaviour.
module irqc_pin_edge #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    input  logic [N-1:0] rise_i,
    output logic [N-1:0] edge_o
);
    logic [N-1:0] meta_q;
    logic [N-1:0] sync_q;
    logic [N-1:0] prev_q;
    logic [N-1:0] act_w;

    // Active level: the pin itself for rising, its inverse for falling.
    assign act_w  = ~(sync_q ^ rise_i);
    assign edge_o = act_w & ~prev_q;

    // Two-flop synchronizer and previous-active-level store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '1;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
            prev_q <= act_w;
        end
    end
endmodule

// File: rtl/irqc_req_bank.sv
// Module: per-slot source select, request bits and enable bits.
// Assumes triggers are one-cycle pulses; set wins over any clear.
module irqc_req_bank
    import irqc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   trig_i,
    input  logic [NUM_SEL-1:0]   sel_i,
    input  logic                 req_wr_i,
    input  logic [NUM_MSLOT-1:0] req_wdata_i,
    input  logic                 en_wr_i,
    input  logic [NUM_MSLOT-1:0] en_wdata_i,
    input  logic [NUM_MSLOT-1:0] ack_clr_i,
    output logic [NUM_MSLOT-1:0] set_o,
    output logic [NUM_MSLOT-1:0] req_o,
    output logic [NUM_MSLOT-1:0] en_o
);
    logic [NUM_MSLOT-1:0] req_q;
    logic [NUM_MSLOT-1:0] en_q;
    logic [NUM_MSLOT-1:0] keep_w;

    // Route each slot's set pulse from its fixed or selected source.
    for (genvar s = 0; s < NUM_MSLOT; s++) begin : g_slot
        localparam int P = prim_src(s);
        localparam int A = alt_src(s);
        localparam int K = sel_idx(s);
        if (A >= 0) begin : g_shared
            assign set_o[s] = sel_i[K] ? trig_i[A] : trig_i[P];
        end else begin : g_single
            assign set_o[s] = trig_i[P];
        end
    end

    // Software may only clear: a written 0 drops the bit.
    assign keep_w = req_wr_i ? req_wdata_i : '1;

    // Request bits: clear by write or acceptance, hardware set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= (req_q & keep_w & ~ack_clr_i) | set_o;
    end

    // Enable bits: plain software-loaded register.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (en_wr_i) en_q <= en_wdata_i;
    end

    assign req_o = req_q;
    assign en_o  = en_q;
endmodule

// File: rtl/irqc_arb.sv
// Module: fixed-priority picker, lowest index wins.
// Assumes the candidate vector is already masked.
module irqc_arb
    import irqc_pkg::*;
#(
    parameter int N = NUM_CAND
) (
    input  logic [N-1:0]      cand_i,
    output logic              found_o,
    output logic [SLOT_W-1:0] idx_o
);
    // Scan from the lowest priority upward so the lowest index lands last.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand_i[i]) begin
                found_o = 1'b1;
                idx_o   = SLOT_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
// Module: top of the vectored interrupt controller.
// Assumes boundary_i pulses at instruction edges and iflag_i is the core's
// current disable flag; vec_o is meaningful only while take_o is high.
module irq_vector_ctrl
    import irqc_pkg::*;
#(
    parameter logic [VEC_W-1:0] VEC_TOP = 16'hFFFC
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_EXT-1:0]   ext_pin_i,
    input  logic [NUM_EXT-1:0]   ext_rise_i,
    input  logic [NUM_EVT-1:0]   evt_i,
    input  logic [NUM_SEL-1:0]   share_sel_i,
    input  logic                 req_wr_i,
    input  logic [NUM_MSLOT-1:0] req_wdata_i,
    input  logic                 en_wr_i,
    input  logic [NUM_MSLOT-1:0] en_wdata_i,
    input  logic                 brk_i,
    input  logic                 iflag_i,
    input  logic                 boundary_i,
    output logic [NUM_MSLOT-1:0] req_o,
    output logic [NUM_MSLOT-1:0] en_o,
    output logic                 take_o,
    output logic                 set_iflag_o,
    output logic [VEC_W-1:0]     vec_o
);
    localparam logic [SLOT_W-1:0] BRK_IDX = SLOT_W'(NUM_MSLOT);

    logic [NUM_EXT-1:0]   pin_edge_w;
    logic [NUM_SRC-1:0]   trig_w;
    logic [NUM_MSLOT-1:0] slot_set_w;
    logic [NUM_MSLOT-1:0] ack_clr_w;
    logic [NUM_CAND-1:0]  cand_w;
    logic                 found_w;
    logic [SLOT_W-1:0]    idx_w;
    logic                 brk_pend_q;
    logic                 rst_pend_q;
    logic                 take_src_w;

    irqc_pin_edge #(.N(NUM_EXT)) u_pins (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_pin_i),
        .rise_i (ext_rise_i),
        .edge_o (pin_edge_w)
    );

    assign trig_w = {evt_i, pin_edge_w};

    irqc_req_bank u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_i      (trig_w),
        .sel_i       (share_sel_i),
        .req_wr_i    (req_wr_i),
        .req_wdata_i (req_wdata_i),
        .en_wr_i     (en_wr_i),
        .en_wdata_i  (en_wdata_i),
        .ack_clr_i   (ack_clr_w),
        .set_o       (slot_set_w),
        .req_o       (req_o),
        .en_o        (en_o)
    );

    // Maskable candidates gated by enable and the global flag; break is not.
    assign cand_w = {brk_pend_q, req_o & en_o & {NUM_MSLOT{~iflag_i}}};

    irqc_arb #(.N(NUM_CAND)) u_arb (
        .cand_i  (cand_w),
        .found_o (found_w),
        .idx_o   (idx_w)
    );

    // Acceptance and vector: reset entry first, else the arbiter's winner.
    assign take_o      = boundary_i & (rst_pend_q | found_w);
    assign set_iflag_o = take_o;
    assign take_src_w  = take_o & ~rst_pend_q;
    assign vec_o       = rst_pend_q ? VEC_TOP
                       : VEC_TOP - (VEC_W'(idx_w) << 1) - VEC_W'(2);

    // One-hot clear of the accepted maskable slot.
    assign ack_clr_w = (take_src_w && idx_w != BRK_IDX)
                     ? (NUM_MSLOT'(1) << idx_w) : '0;

    // Break request latch: a new strobe wins over acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)                              brk_pend_q <= 1'b0;
        else if (brk_i)                          brk_pend_q <= 1'b1;
        else if (take_src_w && idx_w == BRK_IDX) brk_pend_q <= 1'b0;
    end

    // Reset entry: pending from reset until the first boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)      rst_pend_q <= 1'b1;
        else if (take_o) rst_pend_q <= 1'b0;
    end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
// Module: assertion checker for irq_vector_ctrl, attached with bind.
// Assumes it sees the top's ports plus its break, reset-entry and set state.
module irq_vector_ctrl_chk
    import irqc_pkg::*;
#(
    parameter logic [VEC_W-1:0] VEC_TOP = 16'hFFFC
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 iflag_i,
    input logic                 boundary_i,
    input logic                 en_wr_i,
    input logic [NUM_MSLOT-1:0] en_wdata_i,
    input logic [NUM_MSLOT-1:0] req_o,
    input logic [NUM_MSLOT-1:0] en_o,
    input logic                 take_o,
    input logic [VEC_W-1:0]     vec_o,
    input logic [NUM_MSLOT-1:0] slot_set,
    input logic                 brk_pend,
    input logic                 rst_pend
);
    localparam logic [VEC_W-1:0] BRK_VEC = VEC_TOP - VEC_W'(2 * NUM_CAND);

    a_r10_take_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> boundary_i);

    a_r1_reset_entry_first: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && rst_pend) |-> (vec_o == VEC_TOP));

    a_r8_brk_never_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary_i && brk_pend && !rst_pend) |-> take_o);

    a_r6_flag_leaves_brk_only: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && iflag_i && !rst_pend) |-> (vec_o == BRK_VEC));

    a_r9_vector_even: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> !vec_o[0]);

    a_r4_no_software_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((req_o & ~$past(req_o) & ~$past(slot_set)) == '0));

    a_r5_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr_i |=> (en_o == $past(en_wdata_i)));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.VEC_TOP(VEC_TOP)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .iflag_i    (iflag_i),
    .boundary_i (boundary_i),
    .en_wr_i    (en_wr_i),
    .en_wdata_i (en_wdata_i),
    .req_o      (req_o),
    .en_o       (en_o),
    .take_o     (take_o),
    .vec_o      (vec_o),
    .slot_set   (slot_set_w),
    .brk_pend   (brk_pend_q),
    .rst_pend   (rst_pend_q)
);

// File: tb/irq_vector_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  ext_pin = '0;
    logic [4:0]  ext_rise = '1;
    logic [13:0] evt = '0;
    logic [3:0]  sel = '0;
    logic        req_wr = 1'b0;
    logic [14:0] req_wdata = '0;
    logic        en_wr = 1'b0;
    logic [14:0] en_wdata = '0;
    logic        brk = 1'b0;
    logic        iflag = 1'b1;
    logic        boundary = 1'b0;
    logic [14:0] req_o, en_o;
    logic        take_o, set_iflag_o;
    logic [15:0] vec_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    irq_vector_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin), .ext_rise_i(ext_rise),
        .evt_i(evt), .share_sel_i(sel), .req_wr_i(req_wr), .req_wdata_i(req_wdata),
        .en_wr_i(en_wr), .en_wdata_i(en_wdata), .brk_i(brk), .iflag_i(iflag),
        .boundary_i(boundary), .req_o(req_o), .en_o(en_o), .take_o(take_o),
        .set_iflag_o(set_iflag_o), .vec_o(vec_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Source id of a slot under the current select bits (R3 map).
    function automatic int src_of(input int s, input logic [3:0] sl);
        case (s)
            0, 1, 2: return s;
            3:  return 5;
            4:  return sl[0] ? 7 : 6;
            5:  return sl[1] ? 9 : 8;
            12: return 3;
            13: return sl[2] ? 16 : 4;
            14: return sl[3] ? 18 : 17;
            default: return 10 + (s - 6);
        endcase
    endfunction

    // Behavioural reference state.
    bit m_ok = 1'b0;
    bit m_f1[5], m_f2[5], m_pv[5];
    bit m_req[15], m_en[15];
    bit m_brk, m_rst;

    always @(negedge clk) begin : ref_model
        int win;
        bit trig[19];
        bit act;
        logic [14:0] rq, en;
        bit exp_take;
        logic [15:0] exp_vec;
        if (m_ok && rst_n && !done) begin
            win = -1;
            if (m_rst) win = 100;
            else begin
                for (int s = 0; s < 15; s++)
                    if (win < 0 && m_req[s] && m_en[s] && !iflag) win = s;
                if (win < 0 && m_brk) win = 15;
            end
            exp_take = boundary && (win >= 0);
            exp_vec  = (win == 100) ? 16'hFFFC : 16'(16'hFFFA - 2 * win);
            for (int s = 0; s < 15; s++) begin rq[s] = m_req[s]; en[s] = m_en[s]; end
            chk("R4 req_o", 32'(req_o), 32'(rq));
            chk("R5 en_o", 32'(en_o), 32'(en));
            chk("R10 take_o", 32'(take_o), 32'(exp_take));
            chk("R9 set_iflag_o", 32'(set_iflag_o), 32'(exp_take));
            if (exp_take) chk("R7 vec_o", 32'(vec_o), 32'(exp_vec));
            for (int p = 0; p < 5; p++) begin
                act = ext_rise[p] ? m_f2[p] : !m_f2[p];
                trig[p] = act && !m_pv[p];
                m_pv[p] = act;
                m_f2[p] = m_f1[p];
                m_f1[p] = ext_pin[p];
            end
            for (int j = 0; j < 14; j++) trig[5 + j] = evt[j];
            for (int s = 0; s < 15; s++) begin
                if (req_wr && !req_wdata[s]) m_req[s] = 1'b0;
                if (exp_take && win == s) m_req[s] = 1'b0;
                if (trig[src_of(s, sel)]) m_req[s] = 1'b1;
                if (en_wr) m_en[s] = en_wdata[s];
            end
            if (exp_take && win == 15) m_brk = 1'b0;
            if (brk) m_brk = 1'b1;
            if (exp_take && win == 100) m_rst = 1'b0;
        end
        if (!rst_n) begin
            for (int p = 0; p < 5; p++) begin m_f1[p] = 0; m_f2[p] = 0; m_pv[p] = 1; end
            for (int s = 0; s < 15; s++) begin m_req[s] = 0; m_en[s] = 0; end
            m_brk = 0;
            m_rst = 1;
            m_ok  = 1;
        end
    end

    task automatic cyc(input int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin : stim
        cyc(3);
        rst_n = 1'b1;
        cyc();
        @(negedge clk);
        chk("R1 req_o after reset", 32'(req_o), 0);
        chk("R1 en_o after reset", 32'(en_o), 0);
        chk("R1 take_o idle", 32'(take_o), 0);
        cyc();
        boundary = 1'b1;
        @(negedge clk);
        chk("R1 reset entry take", 32'(take_o), 1);
        chk("R1 reset entry vector", 32'(vec_o), 32'hFFFC);
        cyc();
        boundary = 1'b0;
        en_wr = 1'b1; en_wdata = '1;
        cyc();
        en_wr = 1'b0;
        chk("R5 enable load", 32'(en_o), 32'h7FFF);
        // R2: rising edge on pin 0
        ext_pin[0] = 1'b1;
        cyc(2);
        chk("R2 not yet set", 32'(req_o[0]), 0);
        cyc();
        chk("R2 rising edge sets slot0", 32'(req_o[0]), 1);
        req_wr = 1'b1; req_wdata = 15'h7FFE;
        cyc();
        req_wr = 1'b0;
        chk("R4 write 0 clears", 32'(req_o), 0);
        ext_pin[0] = 1'b0;
        cyc(4);
        chk("R2 wrong edge ignored", 32'(req_o[0]), 0);
        // R11: polarity flip while pin sits low
        ext_rise[0] = 1'b0;
        cyc();
        chk("R11 polarity flip sets slot0", 32'(req_o[0]), 1);
        ext_rise[0] = 1'b1;
        req_wr = 1'b1; req_wdata = '0;
        cyc();
        req_wr = 1'b0;
        req_wr = 1'b1; req_wdata = '1;
        cyc();
        req_wr = 1'b0;
        chk("R4 write 1 has no effect", 32'(req_o), 0);
        evt[0] = 1'b1; req_wr = 1'b1; req_wdata = '0;
        cyc();
        evt[0] = 1'b0; req_wr = 1'b0;
        chk("R4 set wins over clear", 32'(req_o), 32'h0008);
        // R3: shared slot 4
        evt[2] = 1'b1;
        cyc();
        evt[2] = 1'b0;
        chk("R3 unselected source ignored", 32'(req_o[4]), 0);
        sel[0] = 1'b1; evt[2] = 1'b1;
        cyc();
        evt[2] = 1'b0;
        chk("R3 selected second source", 32'(req_o[4]), 1);
        boundary = 1'b1;
        @(negedge clk);
        chk("R6 flag blocks maskable", 32'(take_o), 0);
        cyc();
        boundary = 1'b0; iflag = 1'b0;
        @(negedge clk);
        chk("R10 no take off boundary", 32'(take_o), 0);
        cyc();
        boundary = 1'b1;
        @(negedge clk);
        chk("R7 take", 32'(take_o), 1);
        chk("R7 slot3 vector", 32'(vec_o), 32'hFFF4);
        chk("R9 set_iflag_o", 32'(set_iflag_o), 1);
        cyc();
        boundary = 1'b0;
        chk("R9 only accepted bit cleared", 32'(req_o), 32'h0010);
        iflag = 1'b1; brk = 1'b1;
        cyc();
        brk = 1'b0; boundary = 1'b1;
        @(negedge clk);
        chk("R8 break taken under flag", 32'(take_o), 1);
        chk("R8 break vector", 32'(vec_o), 32'hFFDC);
        cyc();
        boundary = 1'b0;
        // Random phase, checked by the reference model every cycle.
        for (int i = 0; i < 4000; i++) begin
            ext_pin  = ($urandom % 6 == 0) ? 5'($urandom) : ext_pin;
            ext_rise = ($urandom % 40 == 0) ? 5'($urandom) : ext_rise;
            evt      = ($urandom % 3 == 0) ? 14'(1 << ($urandom % 14)) : '0;
            sel      = ($urandom % 50 == 0) ? 4'($urandom) : sel;
            req_wr   = ($urandom % 9 == 0);
            req_wdata = 15'($urandom);
            en_wr    = ($urandom % 25 == 0);
            en_wdata = 15'($urandom);
            brk      = ($urandom % 30 == 0);
            iflag    = ($urandom % 4 == 0);
            boundary = ($urandom % 3 == 0);
            cyc();
        end
        evt = '0; req_wr = 1'b0; en_wr = 1'b0; brk = 1'b0; boundary = 1'b0;
        cyc(2);
        finish_run();
    end
endmodule